// File: doc/BRIEF.md
# Select-Coded Arithmetic/Logic Unit

A purely combinational W-bit arithmetic/logic unit steered by a single 4-bit function code. The top bit of the code picks one of two sections. The arithmetic section adds operand A to a conditioned copy of operand B and feeds in a carry. The logic section forms one bitwise function of the operands. The unit drives a W-bit result and a carry-out.

The function code is `fsel[3:0]`. `fsel[3]` picks the section. `fsel[2:1]` condition the second adder operand. `fsel[0]` is the adder carry-in. The two code fields overlap: `fsel[1:0]` also selects the logic function, so every arithmetic code has a fixed logic twin. The block holds no state and has no handshake. A result depends only on the current inputs, so a surrounding pipeline places its own registers around it. There is no valid/ready pair, because no transfer ever waits on this block.

Top module: `selcode_alu`

## Requirements
- R1: With `fsel[3]`=0, the second adder operand Y is set by `fsel[2:1]`: 00 gives all zeros, 01 gives B, 10 gives the bitwise complement of B, and 11 gives all ones. `g_out` = (A + Y + `fsel[0]`) mod 2^W.
- R2: Codes 0000 through 0111 produce, in that order: A, A+1, A+B, A+B+1, A+~B, A−B, A−1 and A. Codes 0000 and 0111 both pass A through.
- R3: In arithmetic mode, `cout_out` is bit W of the (W+1)-bit sum A + Y + `fsel[0]`. For example, increment (0001) carries out exactly when A is all ones.
- R4: With `fsel[3]`=1, `{fsel[1],fsel[0]}` selects the logic function: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B, and 11 gives NOT A.
- R5: In logic mode, `fsel[2]` has no effect on either output.
- R6: In logic mode, `cout_out` is 0.
- R7: Decrement (0110) of zero gives all ones with `cout_out`=0. Subtracting B from A when A equals B gives zero with `cout_out`=1.
- R8: For subtraction (0101), `cout_out` is 1 exactly when A ≥ B as unsigned numbers. This is a no-borrow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B |
| fsel | input | 4 | Function code: [3] section, [2:1] Y select, [0] carry-in / logic low select |
| g_out | output | W | Result |
| cout_out | output | 1 | Carry out of the MSB; 0 in logic mode |

## Verification
A fault in the Y conditioning or the carry chain shows at `g_out` and `cout_out` as soon as the inputs settle. Nothing is hidden in state, so every wrong value is visible on the same vector that causes it. The dangerous faults are the code overlaps. A swapped logic select, or a leak of `fsel[2]` into logic mode, produces a plausible but wrong function. The checks therefore pair each logic code with its arithmetic twin and repeat logic codes with `fsel[2]` flipped. Carry faults are caught by corner vectors: all ones, zero, and equal operands.

// File: rtl/selalu_pkg.sv
package selalu_pkg;

  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_B    = 2'b01,
    YS_NOTB = 2'b10,
    YS_ONES = 2'b11
  } ysel_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'b00,
    LG_OR   = 2'b01,
    LG_XOR  = 2'b10,
    LG_NOTA = 2'b11
  } lsel_e;

  typedef struct packed {
    logic  logic_mode;
    ysel_e ysel;
    lsel_e lsel;
    logic  carry;
  } fdecode_t;

  // Shared select wiring: logic select reuses the adder carry-in and Y low bit.
  function automatic fdecode_t decode_fsel(input logic [3:0] f);
    fdecode_t d;
    d.logic_mode = f[3];
    d.ysel       = ysel_e'(f[2:1]);
    d.lsel       = lsel_e'(f[1:0]);
    d.carry      = f[0];
    return d;
  endfunction

endpackage

// File: rtl/selalu_yconds.sv
module selalu_yconds #(
  parameter int W = 8
) (
  input  logic [W-1:0]         b_in,
  input  selalu_pkg::ysel_e    ysel,
  output logic [W-1:0]         y_out
);
  import selalu_pkg::*;

  always_comb begin
    unique case (ysel)
      YS_ZERO: y_out = '0;
      YS_B:    y_out = b_in;
      YS_NOTB: y_out = ~b_in;
      default: y_out = '1;
    endcase
  end
endmodule

// File: rtl/selalu_ripple.sv
module selalu_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         c_in,
  output logic [W-1:0] s_out,
  output logic         c_out
);
  logic [W:0] chain;

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic p, q;
    assign p          = x_in[i] ^ y_in[i];
    assign q          = x_in[i] & y_in[i];
    assign s_out[i]   = p ^ chain[i];
    assign chain[i+1] = q | (p & chain[i]);
  end

  assign c_out = chain[W];
endmodule

// File: rtl/selalu_bitwise.sv
module selalu_bitwise #(
  parameter int W = 8
) (
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  selalu_pkg::lsel_e lsel,
  output logic [W-1:0]      l_out
);
  import selalu_pkg::*;

  always_comb begin
    unique case (lsel)
      LG_AND:  l_out = a_in & b_in;
      LG_OR:   l_out = a_in | b_in;
      LG_XOR:  l_out = a_in ^ b_in;
      default: l_out = ~a_in;
    endcase
  end
endmodule

// File: rtl/selcode_alu.sv
module selcode_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   fsel,
  output logic [W-1:0] g_out,
  output logic         cout_out
);
  import selalu_pkg::*;

  fdecode_t     dec;
  logic [W-1:0] y_cond;
  logic [W-1:0] sum;
  logic         sum_carry;
  logic [W-1:0] lres;

  assign dec = decode_fsel(fsel);

  selalu_yconds #(.W(W)) u_ycond (
    .b_in (b_in),
    .ysel (dec.ysel),
    .y_out(y_cond)
  );

  selalu_ripple #(.W(W)) u_add (
    .x_in (a_in),
    .y_in (y_cond),
    .c_in (dec.carry),
    .s_out(sum),
    .c_out(sum_carry)
  );

  selalu_bitwise #(.W(W)) u_logic (
    .a_in (a_in),
    .b_in (b_in),
    .lsel (dec.lsel),
    .l_out(lres)
  );

  assign g_out    = dec.logic_mode ? lres : sum;
  assign cout_out = dec.logic_mode ? 1'b0 : sum_carry;
endmodule

// File: rtl/selcode_alu_chk.sv
module selcode_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [3:0]   fsel,
  input logic [W-1:0] g_out,
  input logic         cout_out
);
  always_comb begin
    if (fsel[3]) begin
      assert_logic_no_carry_R6: assert (cout_out == 1'b0);
    end
    if (fsel == 4'b1000 || fsel == 4'b1100) begin
      assert_logic_and_R4: assert (g_out == (a_in & b_in));
    end
    if (fsel[3] && fsel[1:0] == 2'b11) begin
      assert_logic_nota_R5: assert (g_out == ~a_in);
    end
    if (fsel == 4'b0101) begin
      assert_sub_noborrow_R8: assert (cout_out == (a_in >= b_in));
    end
    if (fsel == 4'b0000 || fsel == 4'b0111) begin
      assert_pass_a_R2: assert (g_out == a_in);
    end
    if (fsel == 4'b0001) begin
      assert_inc_carry_R3: assert (cout_out == (a_in == {W{1'b1}}));
    end
  end
endmodule

bind selcode_alu selcode_alu_chk #(.W(W)) u_chk (
  .a_in    (a_in),
  .b_in    (b_in),
  .fsel    (fsel),
  .g_out   (g_out),
  .cout_out(cout_out)
);

// File: tb/selcode_alu_bench.sv
module selcode_alu_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0]   f;
  logic [W-1:0] g;
  logic         co;
  int           n_chk  = 0;
  int           n_fail = 0;
  logic [31:0]  lfsr   = 32'h1ACE_B00C;

  always #4 clk = ~clk;

  selcode_alu #(.W(W)) u_selcode_alu (
    .a_in(a), .b_in(b), .fsel(f), .g_out(g), .cout_out(co)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s f=%b a=%h b=%h actual=%h expected=%h", req, f, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic [3:0] fv);
    @(negedge clk);
    a = av; b = bv; f = fv;
    #2;
  endtask

  function automatic logic [W:0] model(input logic [W-1:0] av, input logic [W-1:0] bv,
                                       input logic [3:0] fv);
    logic [W-1:0] y;
    if (fv[3]) begin
      case (fv[1:0])
        2'b00: return {1'b0, av & bv};
        2'b01: return {1'b0, av | bv};
        2'b10: return {1'b0, av ^ bv};
        default: return {1'b0, ~av};
      endcase
    end
    case (fv[2:1])
      2'b00: y = '0;
      2'b01: y = bv;
      2'b10: y = ~bv;
      default: y = '1;
    endcase
    return {1'b0, av} + {1'b0, y} + {{W{1'b0}}, fv[0]};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic t_idle;
    apply('0, '0, 4'b0000);
    check("R2 idle zero", {co, g}, '0);
  endtask

  task automatic t_arith_table;
    apply(8'h5C, 8'h27, 4'b0000); check("R2 pass", {co, g}, {1'b0, 8'h5C});
    apply(8'h5C, 8'h27, 4'b0001); check("R2 inc",  {co, g}, {1'b0, 8'h5D});
    apply(8'h5C, 8'h27, 4'b0010); check("R2 add",  {co, g}, {1'b0, 8'h83});
    apply(8'h5C, 8'h27, 4'b0011); check("R2 add1", {co, g}, {1'b0, 8'h84});
    apply(8'h5C, 8'h27, 4'b0100); check("R1 a+~b", {co, g}, {1'b1, 8'h34});
    apply(8'h5C, 8'h27, 4'b0101); check("R2 sub",  {co, g}, {1'b1, 8'h35});
    apply(8'h5C, 8'h27, 4'b0110); check("R2 dec",  {co, g}, {1'b1, 8'h5B});
    apply(8'h5C, 8'h27, 4'b0111); check("R2 pass2",{co, g}, {1'b1, 8'h5C});
  endtask

  task automatic t_carry_corners;
    apply(8'hFF, 8'h00, 4'b0001); check("R3 inc wrap", {co, g}, {1'b1, 8'h00});
    apply(8'hFE, 8'h00, 4'b0001); check("R3 inc nowrap", {co, g}, {1'b0, 8'hFF});
    apply(8'hC0, 8'h80, 4'b0010); check("R3 add carry", {co, g}, {1'b1, 8'h40});
    apply(8'h00, 8'h00, 4'b0110); check("R7 dec zero", {co, g}, {1'b0, 8'hFF});
    apply(8'h6A, 8'h6A, 4'b0101); check("R7 sub equal", {co, g}, {1'b1, 8'h00});
    apply(8'h10, 8'h11, 4'b0101); check("R8 borrow", {co, g}, {1'b0, 8'hFF});
  endtask

  task automatic t_logic;
    apply(8'hCA, 8'h5F, 4'b1000); check("R4 and", {co, g}, {1'b0, 8'h4A});
    apply(8'hCA, 8'h5F, 4'b1001); check("R4 or",  {co, g}, {1'b0, 8'hDF});
    apply(8'hCA, 8'h5F, 4'b1010); check("R4 xor", {co, g}, {1'b0, 8'h95});
    apply(8'hCA, 8'h5F, 4'b1011); check("R4 nota",{co, g}, {1'b0, 8'h35});
    apply(8'hFF, 8'hFF, 4'b1001); check("R6 no carry", {co, g}, {1'b0, 8'hFF});
  endtask

  task automatic t_s1_ignored;
    for (int c = 0; c < 4; c++) begin
      apply(8'h96, 8'h3C, {2'b11, c[1:0]});
      check("R5 s1 ignored", {co, g}, model(8'h96, 8'h3C, {2'b10, c[1:0]}));
    end
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] av, bv;
      logic [3:0]   fv;
      lfsr = step(lfsr); av = lfsr[7:0];
      lfsr = step(lfsr); bv = lfsr[7:0];
      lfsr = step(lfsr); fv = lfsr[3:0];
      apply(av, bv, fv);
      check("R1 sweep", {co, g}, model(av, bv, fv));
      if (fv == 4'b0101) check("R8 sweep", {8'h00, co}, {8'h00, av >= bv});
    end
  endtask

  initial begin
    a = '0; b = '0; f = '0;
    repeat (2) @(posedge clk);
    t_idle;
    t_arith_table;
    t_carry_corners;
    t_logic;
    t_s1_ignored;
    t_sweep;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule